// File: doc/BRIEF.md
# Bit-Serial Complex Coefficient Multiplier

This block multiplies a variable complex operand X = a + jb by a complex constant K = c + jd that is fixed at elaboration. No multiplier is used. Only two precomputed constants are kept: the sum c+d and the difference c-d. Both are one bit wider than the coefficients, so they cannot overflow. Each operand part is a two's-complement word. A start strobe loads it in parallel, and it is then shifted out least-significant bit first. Two shift-accumulators, one for the real part and one for the imaginary part, each take one of the two constants per cycle. A swap multiplexer driven by the exclusive-or of the current operand bits picks which constant goes where. Each accumulator then adds or subtracts its constant according to its own operand bit.

The operand bits are treated as signed ±1 digits (offset-binary form). Each accumulator therefore starts from a preset value that equals its table entry for the all-zero bit pair. That preset carries the constant offset term at the same weight as the first digit. After one cycle per operand bit, both exact products ac-bd and ad+bc are written to registered outputs, and a shared done flag pulses.

Top module: `dacm_top`

## Requirements
- R1: While reset is high and after it is released, `re_out` and `im_out` are 0 and `done` and `busy` are 0 until the first result.
- R2: `re_out` equals the exact two's-complement value of C_RE·a − C_IM·b, where a and b are the signed `a_in`/`b_in` words captured at the accepted start. It is DW+CW+1 bits wide.
- R3: `im_out` equals the exact two's-complement value of C_IM·a + C_RE·b for the same captured operands, at the same width.
- R4: A start is accepted on a rising edge where `start`=1 and `busy`=0. `busy` is 1 for exactly DW cycles after that edge. `done` is 1 for exactly one cycle, first visible DW edges after the accepting edge, and the new results appear in that same cycle.
- R5: A `start` pulse while `busy`=1 is ignored: the operands and the result of the computation in flight are unchanged.
- R6: `re_out` and `im_out` change only in a cycle where `done`=1 and hold their value otherwise.
- R7: The most negative operand values (−2^(DW−1) for a, b or both) give exact results, with no overflow.
- R8: `done` and `busy` are never 1 in the same cycle, so a new start may be given in the cycle that `done` is shown.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin a product |
| a_in | input | DW | Real part of the operand, two's complement |
| b_in | input | DW | Imaginary part of the operand, two's complement |
| re_out | output | DW+CW+1 | Real part of the product, registered |
| im_out | output | DW+CW+1 | Imaginary part of the product, registered |
| done | output | 1 | One-cycle pulse when new results are valid |
| busy | output | 1 | High while operand bits are being consumed |

## Verification
Two things can coincide. In the cycle where one product is delivered (`done` high), a new `start` may arrive and must be accepted, because `busy` has already dropped. The bench waits for `done` on a falling edge and raises `start` in that same cycle with fresh operands. It then expects both the delivered result and the following one in order from its queue. A second case is a start that lands mid-computation. It is given no queue entry, so any disturbance shows up as a mismatch against the first operand's product.

// File: rtl/dacm_pkg.sv
package dacm_pkg;
  // one serial step: current operand bits plus sign-weight flag
  typedef struct packed {
    logic bit_a;
    logic bit_b;
    logic sign_cyc;
  } dacm_slice_t;
endpackage

// File: rtl/dacm_ctrl.sv
module dacm_ctrl
  import dacm_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] a_in,
  input  logic [DW-1:0] b_in,
  output dacm_slice_t   slice,
  output logic          load,
  output logic          step,
  output logic          last,
  output logic          busy
);
  localparam int CNTW = $clog2(DW + 1);

  logic [DW-1:0]   sh_a, sh_b;
  logic [CNTW-1:0] cnt;

  assign load = start & ~busy;
  assign step = busy;
  assign last = busy && (cnt == CNTW'(DW - 1));

  assign slice.bit_a    = sh_a[0];
  assign slice.bit_b    = sh_b[0];
  assign slice.sign_cyc = last;

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_a <= '0;
      sh_b <= '0;
      cnt  <= '0;
      busy <= 1'b0;
    end else if (load) begin
      sh_a <= a_in;
      sh_b <= b_in;
      cnt  <= '0;
      busy <= 1'b1;
    end else if (busy) begin
      sh_a <= sh_a >> 1;
      sh_b <= sh_b >> 1;
      cnt  <= cnt + 1'b1;
      if (last) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/dacm_lane.sv
module dacm_lane #(
  parameter int CW = 8,
  parameter int DW = 8,
  parameter int AW = CW + 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    step,
  input  logic signed [AW-1:0]    preset,
  input  logic signed [CW:0]      coef,
  input  logic                    add_dir,
  output logic signed [AW+DW-3:0] prod
);
  logic signed [AW-1:0] acc, term_ext, term, sum_w;
  logic [DW-1:0]        lo;

  assign term_ext = {{(AW-CW-1){coef[CW]}}, coef};
  assign term     = add_dir ? term_ext : -term_ext;
  assign sum_w    = acc + term;
  // {sum_w, lo[DW-1:1]} is twice the product; its LSB is always zero
  assign prod     = {sum_w, lo[DW-1:2]};

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      lo  <= '0;
    end else if (load) begin
      acc <= preset;
      lo  <= '0;
    end else if (step) begin
      acc <= sum_w >>> 1;
      lo  <= {sum_w[0], lo[DW-1:1]};
    end
  end
endmodule

// File: rtl/dacm_top.sv
module dacm_top
  import dacm_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 8,
  parameter logic signed [CW-1:0] C_RE = 8'sd77,
  parameter logic signed [CW-1:0] C_IM = -8'sd45
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [DW-1:0]          a_in,
  input  logic [DW-1:0]          b_in,
  output logic [DW+CW:0]         re_out,
  output logic [DW+CW:0]         im_out,
  output logic                   done,
  output logic                   busy
);
  localparam int AW = CW + 3;
  localparam int PW = DW + CW + 1;

  localparam logic signed [CW:0] K_SUM =
    $signed({C_RE[CW-1], C_RE}) + $signed({C_IM[CW-1], C_IM});
  localparam logic signed [CW:0] K_DIF =
    $signed({C_RE[CW-1], C_RE}) - $signed({C_IM[CW-1], C_IM});
  // presets: table entry for bit pair (0,0) of each part
  localparam logic signed [AW-1:0] PRE_RE = -$signed({{(AW-CW-1){K_DIF[CW]}}, K_DIF});
  localparam logic signed [AW-1:0] PRE_IM = -$signed({{(AW-CW-1){K_SUM[CW]}}, K_SUM});

  dacm_slice_t slice;
  logic load, step, last;

  dacm_ctrl #(.DW(DW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .slice(slice), .load(load), .step(step), .last(last), .busy(busy)
  );

  // swap multiplexer: differing bits send the sum to the real side
  logic              differ;
  logic signed [CW:0] coef_re, coef_im;
  assign differ  = slice.bit_a ^ slice.bit_b;
  assign coef_re = differ ? K_SUM : K_DIF;
  assign coef_im = differ ? K_DIF : K_SUM;

  logic signed [PW-1:0] prod_re, prod_im;

  dacm_lane #(.CW(CW), .DW(DW), .AW(AW)) u_lane_re (
    .clk(clk), .rst(rst), .load(load), .step(step), .preset(PRE_RE),
    .coef(coef_re), .add_dir(slice.bit_a ^ slice.sign_cyc), .prod(prod_re)
  );

  dacm_lane #(.CW(CW), .DW(DW), .AW(AW)) u_lane_im (
    .clk(clk), .rst(rst), .load(load), .step(step), .preset(PRE_IM),
    .coef(coef_im), .add_dir(slice.bit_b ^ slice.sign_cyc), .prod(prod_im)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      re_out <= '0;
      im_out <= '0;
      done   <= 1'b0;
    end else begin
      done <= last;
      if (last) begin
        re_out <= prod_re;
        im_out <= prod_im;
      end
    end
  end
endmodule

// File: rtl/dacm_chk.sv
module dacm_chk #(
  parameter int DW = 8,
  parameter int PW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic [PW-1:0] re_out,
  input logic [PW-1:0] im_out
);
  logic [15:0] busy_len;
  always_ff @(posedge clk) begin
    if (rst)       busy_len <= '0;
    else if (busy) busy_len <= busy_len + 1'b1;
    else           busy_len <= '0;
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R4
  AST_START_TAKEN: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy); // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (rst)
    done |-> (busy_len == 16'(DW))); // R4
  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
    !(done && busy)); // R8
  AST_HOLD_RESULT: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(re_out) && $stable(im_out))); // R6
  AST_BUSY_KEEP: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> (busy || done)); // R5
endmodule

bind dacm_top dacm_chk #(.DW(DW), .PW(DW + CW + 1)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done),
  .re_out(re_out), .im_out(im_out)
);

// File: tb/tb_dacm_top.sv
module tb_dacm_top;
  localparam int DW = 8;
  localparam int CW = 8;
  localparam int PW = DW + CW + 1;
  localparam int C_RE = 77;
  localparam int C_IM = -45;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [DW-1:0] a_in = '0, b_in = '0;
  logic [PW-1:0] re_out, im_out;
  logic done, busy;

  int checks = 0;
  int fails = 0;
  logic [PW-1:0] q_re[$];
  logic [PW-1:0] q_im[$];
  string         q_tag[$];
  logic [PW-1:0] last_re, last_im;

  always #2.5 clk = ~clk;

  dacm_top #(.DW(DW), .CW(CW)) dut (
    .clk(clk), .rst(rst), .start(start), .a_in(a_in), .b_in(b_in),
    .re_out(re_out), .im_out(im_out), .done(done), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic push_exp(input int a, input int b, input string tag);
    longint re, im;
    re = longint'(C_RE) * a - longint'(C_IM) * b;
    im = longint'(C_IM) * a + longint'(C_RE) * b;
    q_re.push_back(PW'(re));
    q_im.push_back(PW'(im));
    q_tag.push_back(tag);
  endtask

  // driver: called at a falling edge, returns one falling edge later
  task automatic drive(input int a, input int b, input string tag);
    a_in  = DW'(a);
    b_in  = DW'(b);
    start = 1'b1;
    push_exp(a, b, tag);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(input int a, input int b, input string tag);
    while (busy) @(negedge clk);
    drive(a, b, tag);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (!rst && done) begin
      check(!busy, "R8 done with busy", busy, 0);
      if (q_re.size() == 0) begin
        check(1'b0, "R4 unexpected done", 1, 0);
      end else begin
        logic [PW-1:0] er, ei;
        string tg;
        er = q_re.pop_front();
        ei = q_im.pop_front();
        tg = q_tag.pop_front();
        check(re_out == er, {"R2 real ", tg}, $signed(re_out), $signed(er));
        check(im_out == ei, {"R3 imag ", tg}, $signed(im_out), $signed(ei));
        last_re = re_out;
        last_im = im_out;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int lat;
    repeat (3) @(negedge clk);
    check(re_out == 0 && im_out == 0, "R1 outputs in reset", re_out, 0);
    rst = 1'b0;
    @(negedge clk);
    check(done == 0 && busy == 0, "R1 flags after reset", {done, busy}, 0);
    check(re_out == 0 && im_out == 0, "R1 outputs after reset", im_out, 0);

    // R4 latency counted at the ports
    drive(3, -5, "R4 latency");
    lat = 1;
    while (!done && lat < 50) begin @(negedge clk); lat++; end
    check(lat == DW + 1, "R4 done latency", lat, DW + 1);
    @(negedge clk);
    check(done == 0, "R4 done single cycle", done, 0);

    run_op(0, 0, "zero");
    run_op(1, 0, "unit real");
    run_op(0, 1, "unit imag");
    run_op(-1, -1, "minus one");
    run_op(-128, -128, "R7 both min");
    run_op(127, -128, "R7 b min");
    run_op(-128, 127, "R7 a min");

    // R8: new start in the same cycle as done
    run_op(55, -77, "R8 first");
    while (!done) @(negedge clk);
    drive(-99, 13, "R8 back to back");

    // R5: start mid-computation must be ignored
    run_op(21, 100, "R5 in flight");
    @(negedge clk);
    @(negedge clk);
    a_in = DW'(-7); b_in = DW'(9); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    @(negedge clk);

    // R6: result holds after done
    repeat (4) @(negedge clk);
    check(re_out == last_re, "R6 real hold", re_out, last_re);
    check(im_out == last_im, "R6 imag hold", im_out, last_im);

    for (int i = 0; i < 20; i++) begin
      int ra, rb;
      ra = int'($signed(DW'($urandom)));
      rb = int'($signed(DW'($urandom)));
      run_op(ra, rb, "random");
    end

    while (q_re.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule